// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers a set of interrupt source lines, one bit per source, and folds them into a single request line toward a parent interrupt controller. Software reaches it through a small register bus. It can read the per-source status and the current mask, and it changes the mask through two write-one registers: one sets mask bits and the other clears them. Because of this, no read-modify-write sequence is ever needed to enable or disable a single source.

A build-time parameter picks one of two variants, and each variant has its own address map. The latched variant records every rising edge of a source in a sticky status bit. That bit stays set until software writes a one to the matching bit of an acknowledge register. The level variant has no storage for status: its status read shows the source lines as they are right now, and it has no acknowledge register. In both variants a source is pending when its status bit is 1 and its mask bit is 0. The parent request is a registered OR of all pending bits.

The register bus is a plain single-cycle control port with no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is driven combinationally during any cycle where `bus_rd` is high.

Top module: `irq_aggregator_l2`

## Requirements
- R1: After reset every mask bit is 1 (all sources disabled), every latched status bit is 0, and `irq_out` is 0.
- R2: Writing to the mask-set register (offset 0x10 in the latched variant, 0x08 in the level variant) sets every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R3: Writing to the mask-clear register (offset 0x14 in the latched variant, 0x0C in the level variant) clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: Reading the mask readback register (offset 0x0C in the latched variant, 0x04 in the level variant) returns the mask, where bit n = 1 means source n is masked.
- R5: In the latched variant, a 0-to-1 transition on a source sets its status bit (read at offset 0x00). The bit stays set after the source falls.
- R6: In the level variant, the status read at offset 0x00 equals the source lines. There is no acknowledge register: a write to 0x08 acts only as a mask set.
- R7: In the latched variant, writing a 1 to bit n of the acknowledge register (offset 0x08) clears status bit n.
- R8: In the latched variant, if a rising edge on source n arrives in the same cycle as an acknowledge of bit n, the status bit stays set.
- R9: `irq_out` is 1 exactly one clock after any bit of status AND NOT mask is 1, and 0 one clock after none is.
- R10: A mask-set write followed in the next cycle by an acknowledge write of the same bit leaves that source masked, with its status cleared.
- R11: Reads of the mask-set, mask-clear and acknowledge registers, and of any offset outside the map, return 0. Writes to offsets outside the map change nothing.
- R12: Masking a source never clears its status bit. A latched event that arrived while the source was masked raises `irq_out` after the source is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Interrupt source lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | NSRC | Write data, one bit per source |
| bus_rdata | output | NSRC | Read data; 0 when not reading |
| irq_out | output | 1 | Registered request to the parent controller |

## Verification
The bench builds two instances side by side, both with 32 sources and 8-bit offsets. One has LATCHED=1 and the other LATCHED=0, so both address maps are exercised against the same expectations for mask handling. The latched instance reaches the sticky-edge, acknowledge, edge-versus-acknowledge and mask-then-acknowledge cases. The level instance shows that offset 0x08 takes on the mask-set role and that status follows the source lines with one cycle less latency to `irq_out`.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  // Decoded register hits for one bus access
  typedef struct packed {
    logic status;
    logic ack;
    logic mask_rb;
    logic mask_set;
    logic mask_clr;
  } reg_sel_t;

  // Latched variant map
  localparam logic [7:0] LAT_STATUS = 8'h00;
  localparam logic [7:0] LAT_ACK    = 8'h08;
  localparam logic [7:0] LAT_MASKRB = 8'h0C;
  localparam logic [7:0] LAT_MSET   = 8'h10;
  localparam logic [7:0] LAT_MCLR   = 8'h14;

  // Level variant map
  localparam logic [7:0] LVL_STATUS = 8'h00;
  localparam logic [7:0] LVL_MASKRB = 8'h04;
  localparam logic [7:0] LVL_MSET   = 8'h08;
  localparam logic [7:0] LVL_MCLR   = 8'h0C;
endpackage

// File: rtl/l2irq_decode.sv
module l2irq_decode
  import l2irq_pkg::*;
#(
  parameter bit          LATCHED = 1'b1,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  generate
    if (LATCHED) begin : g_lat_map
      assign sel.status   = (addr == ADDR_W'(LAT_STATUS));
      assign sel.ack      = (addr == ADDR_W'(LAT_ACK));
      assign sel.mask_rb  = (addr == ADDR_W'(LAT_MASKRB));
      assign sel.mask_set = (addr == ADDR_W'(LAT_MSET));
      assign sel.mask_clr = (addr == ADDR_W'(LAT_MCLR));
    end else begin : g_lvl_map
      assign sel.status   = (addr == ADDR_W'(LVL_STATUS));
      assign sel.ack      = 1'b0;
      assign sel.mask_rb  = (addr == ADDR_W'(LVL_MASKRB));
      assign sel.mask_set = (addr == ADDR_W'(LVL_MSET));
      assign sel.mask_clr = (addr == ADDR_W'(LVL_MCLR));
    end
  endgenerate
endmodule

// File: rtl/l2irq_status.sv
module l2irq_status #(
  parameter bit          LATCHED = 1'b1,
  parameter int unsigned NSRC    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] ack_bits,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] edge_hit
);
  generate
    if (LATCHED) begin : g_sticky
      logic [NSRC-1:0] prev_q;
      logic [NSRC-1:0] st_q;

      assign edge_hit = src & ~prev_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= '0;
          st_q   <= '0;
        end else begin
          prev_q <= src;
          // a fresh edge outranks an acknowledge of the same bit
          st_q   <= (st_q & ~ack_bits) | edge_hit;
        end
      end
      assign status = st_q;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = ^{ack_bits, clk, rst_n};
      assign edge_hit   = '0;
      assign status     = src;
    end
  endgenerate
endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_bits,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] mask
);
  logic [NSRC-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= (mask_q | set_bits) & ~clr_bits;
  end
  assign mask = mask_q;
endmodule

// File: rtl/irq_aggregator_l2.sv
module irq_aggregator_l2
  import l2irq_pkg::*;
#(
  parameter bit          LATCHED = 1'b1,
  parameter int unsigned NSRC    = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_out
);
  reg_sel_t        sel;
  logic [NSRC-1:0] set_bits, clr_bits, ack_bits;
  logic [NSRC-1:0] status, edge_hit, mask_q, pending;
  logic            irq_q;

  l2irq_decode #(.LATCHED(LATCHED), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign set_bits = (bus_wr && sel.mask_set) ? bus_wdata : '0;
  assign clr_bits = (bus_wr && sel.mask_clr) ? bus_wdata : '0;
  assign ack_bits = (bus_wr && sel.ack)      ? bus_wdata : '0;

  l2irq_mask #(.NSRC(NSRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .mask     (mask_q)
  );

  l2irq_status #(.LATCHED(LATCHED), .NSRC(NSRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_irq),
    .ack_bits (ack_bits),
    .status   (status),
    .edge_hit (edge_hit)
  );

  assign pending = status & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end
  assign irq_out = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel.status)       bus_rdata = status;
      else if (sel.mask_rb) bus_rdata = mask_q;
    end
  end
endmodule

// File: rtl/l2irq_checker.sv
module l2irq_checker
  import l2irq_pkg::*;
#(
  parameter bit          LATCHED = 1'b1,
  parameter int unsigned NSRC    = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_wdata,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   edge_hit,
  input logic [NSRC-1:0]   pending,
  input logic              irq_out
);
  logic hit_set, hit_clr;
  assign hit_set = bus_addr == ADDR_W'(LATCHED ? LAT_MSET : LVL_MSET);
  assign hit_clr = bus_addr == ADDR_W'(LATCHED ? LAT_MCLR : LVL_MCLR);

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_set) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_clr) |=> ((mask_q & $past(bus_wdata)) == '0));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |=> irq_out);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |=> !irq_out);

  generate
    if (LATCHED) begin : g_lat_chk
      logic hit_ack;
      assign hit_ack = bus_addr == ADDR_W'(LAT_ACK);

      assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ack) |=>
          ((status & $past(bus_wdata) & ~$past(edge_hit)) == '0));

      assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

      assert_mask_keeps_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_set) |=> ((status & $past(status)) == $past(status)));
    end
  endgenerate
endmodule

bind irq_aggregator_l2 l2irq_checker #(
  .LATCHED (LATCHED),
  .NSRC    (NSRC),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mask_q    (mask_q),
  .status    (status),
  .edge_hit  (edge_hit),
  .pending   (pending),
  .irq_out   (irq_out)
);

// File: tb/test_irq_aggregator_l2.sv
`timescale 1ns/1ps
module test_irq_aggregator_l2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // latched instance
  logic [31:0] src, wdata, rdata;
  logic        wr = 1'b0, rd = 1'b0, irq;
  logic [7:0]  addr;
  // level instance
  logic [31:0] src_l, wdata_l, rdata_l;
  logic        wr_l = 1'b0, rd_l = 1'b0, irq_l;
  logic [7:0]  addr_l;

  int nchk = 0;
  int nerr = 0;

  irq_aggregator_l2 #(.LATCHED(1'b1), .NSRC(32), .ADDR_W(8)) i_irq_aggregator_l2 (
    .clk(clk), .rst_n(rst_n), .src_irq(src), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

  irq_aggregator_l2 #(.LATCHED(1'b0), .NSRC(32), .ADDR_W(8)) i_irq_aggregator_l2_lvl (
    .clk(clk), .rst_n(rst_n), .src_irq(src_l), .bus_wr(wr_l), .bus_rd(rd_l),
    .bus_addr(addr_l), .bus_wdata(wdata_l), .bus_rdata(rdata_l), .irq_out(irq_l));

  typedef struct packed {
    logic [31:0] src;
    logic        wr;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 1'b1, 8'h14, 32'h0000_00FF, 8'h0C, 32'hFFFF_FF00, 8'd3},  // R3 unmask 0..7
    '{32'h1, 1'b0, 8'h00, 32'h0,         8'h00, 32'h0000_0001, 8'd5},  // R5 edge latched
    '{32'h0, 1'b0, 8'h00, 32'h0,         8'h00, 32'h0000_0001, 8'd5},  // R5 sticky after fall
    '{32'h0, 1'b1, 8'h08, 32'h0000_0001, 8'h00, 32'h0,         8'd7},  // R7 ack clears
    '{32'h2, 1'b1, 8'h08, 32'h0000_0002, 8'h00, 32'h0000_0002, 8'd8},  // R8 edge beats ack
    '{32'h2, 1'b1, 8'h10, 32'h0000_0002, 8'h0C, 32'hFFFF_FF02, 8'd2},  // R2 mask set
    '{32'h2, 1'b1, 8'h08, 32'h0000_0002, 8'h00, 32'h0,         8'd10}, // R10 ack after mask
    '{32'h2, 1'b0, 8'h00, 32'h0,         8'h0C, 32'hFFFF_FF02, 8'd10}, // R10 still masked
    '{32'h6, 1'b1, 8'h10, 32'h0,         8'h0C, 32'hFFFF_FF02, 8'd2},  // R2 zero bits no effect
    '{32'h0, 1'b1, 8'h10, 32'h0000_0004, 8'h00, 32'h0000_0004, 8'd12}, // R12 mask keeps status
    '{32'h0, 1'b0, 8'h00, 32'h0,         8'h10, 32'h0,         8'd11}, // R11 mask-set reads 0
    '{32'h0, 1'b1, 8'h20, 32'hFFFF_FFFF, 8'h0C, 32'hFFFF_FF06, 8'd11}, // R11 unmapped write, R4
    '{32'h0, 1'b0, 8'h00, 32'h0,         8'h04, 32'h0,         8'd11}  // R11 unmapped read
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_lat(input logic [7:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a; #1; d = rdata; rd = 1'b0;
  endtask

  task automatic rd_lvl(input logic [7:0] a, output logic [31:0] d);
    rd_l = 1'b1; addr_l = a; #1; d = rdata_l; rd_l = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    src = '0; wdata = '0; addr = '0;
    src_l = '0; wdata_l = '0; addr_l = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_lat(8'h0C, d); chk("R1 latched mask", d, 32'hFFFF_FFFF);
    rd_lat(8'h00, d); chk("R1 latched status", d, 32'h0);
    chk("R1 latched irq", {31'b0, irq}, 32'h0);
    rd_lvl(8'h04, d); chk("R1 level mask", d, 32'hFFFF_FFFF);
    chk("R1 level irq", {31'b0, irq_l}, 32'h0);

    // table walk on the latched instance
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src = VECS[i].src; wr = VECS[i].wr; addr = VECS[i].waddr; wdata = VECS[i].wdata;
      @(negedge clk);
      wr = 1'b0;
      rd_lat(VECS[i].raddr, d);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R12 / R9: masked latched event becomes pending on unmask
    chk("R12 masked no irq", {31'b0, irq}, 32'h0);
    @(negedge clk); wr = 1'b1; addr = 8'h14; wdata = 32'h4;
    @(negedge clk); wr = 1'b0;
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 irq after unmask", {31'b0, irq}, 32'h1);
    wr = 1'b1; addr = 8'h08; wdata = 32'h4;
    @(negedge clk); wr = 1'b0;
    chk("R9 irq one cycle lag", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq falls", {31'b0, irq}, 32'h0);
    rd_lat(8'h08, d); chk("R11 ack reads zero", d, 32'h0);
    rd_lat(8'h14, d); chk("R11 mask-clear reads zero", d, 32'h0);

    // level instance
    wr_l = 1'b1; addr_l = 8'h0C; wdata_l = 32'h1;
    @(negedge clk); wr_l = 1'b0;
    rd_lvl(8'h04, d); chk("R3 level unmask", d, 32'hFFFF_FFFE);
    src_l = 32'h1;
    rd_lvl(8'h00, d); chk("R6 level status follows", d, 32'h1);
    @(negedge clk);
    chk("R9 level irq", {31'b0, irq_l}, 32'h1);
    src_l = 32'h0;
    rd_lvl(8'h00, d); chk("R6 level status drops", d, 32'h0);
    @(negedge clk);
    chk("R9 level irq falls", {31'b0, irq_l}, 32'h0);
    wr_l = 1'b1; addr_l = 8'h08; wdata_l = 32'h1;
    @(negedge clk); wr_l = 1'b0;
    rd_lvl(8'h04, d); chk("R6 level 0x08 is mask set", d, 32'hFFFF_FFFF);
    rd_lvl(8'h14, d); chk("R11 level unmapped read", d, 32'h0);
    src_l = 32'h1;
    @(negedge clk); @(negedge clk);
    chk("R12 level masked no irq", {31'b0, irq_l}, 32'h0);

    summary();
    $finish;
  end
endmodule